// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block turns characters written by a host into asynchronous serial frames on a single output line. A frame opens with a low start bit, carries 5 to 8 data bits least significant first, adds an optional parity bit, and closes with a high stop interval of one, one and a half, or two bit times. Bit timing is derived from a separate transmit clock input. Each bit lasts 1, 16 or 64 periods of that clock, and the line changes only after a falling edge of it.

The transmitter is double buffered. One character waits in a holding register while the previous one shifts out, so consecutive frames leave with no idle gap. A ready flag shows when the holding register can take a new character. An empty flag shows when nothing is waiting and nothing is being sent.

Transmission is gated by an enable input and an active-low clear-to-send input. A character committed before the gate closes is still sent. A character written while the gate is closed waits until the gate opens. A break input forces the line low for as long as it is held. The framing configuration comes from a control sequencer and is captured when each frame starts.

Top module: `sertx_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight and break is off, `txd` is high; `txRdy` and `txEmpty` are high after reset.
- R2: A frame is: one low start bit, then `5 + cfgDataBits` data bits (encoding 0..3 gives 5..8 bits), least significant first, then a parity bit if `cfgParityEn` is 1, then the high stop interval. Bits of `wrByte` above the configured count are not sent and do not affect parity.
- R3: With `cfgParityEven` = 1 the parity bit equals the XOR of the sent data bits (even parity); with 0 it is the inverse of that XOR (odd parity).
- R4: Each start, data and parity bit lasts 1, 16 or 64 `txClk` periods for `cfgRate` = 0, 1, or 2/3. `txd` changes only in the few system cycles after a falling edge of `txClk`.
- R5: The stop interval lasts 1 bit for `cfgStop` = 0, 2 bits for `cfgStop` = 2 or 3, and 1.5 bits for `cfgStop` = 1 (24 or 96 periods at rate 16 or 64). At rate 1, a 1.5-bit stop lasts 2 periods.
- R6: `txRdy` is low from the cycle after a write until the held character moves into the shifter. A character written while another is shifting goes out directly after it, with no idle bit between.
- R7: `txEmpty` is high when no committed character is held and no frame is in flight. A write while the gate is open drops it on the next cycle.
- R8: While `txEnable` is 0 or `ctsN` is 1, no new frame starts from an uncommitted character. A frame in flight, and a character written while the gate was open, still go out. After that `txd` and `txEmpty` are high.
- R9: A character written while the gate is closed leaves `txEmpty` high and is sent once the gate opens.
- R10: A write while the holding register is full replaces the held character; only the latest one is sent.
- R11: While `sendBreak` is 1, `txd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txClk | input | 1 | Transmit bit clock, asynchronous to `clk` |
| cfgDataBits | input | 2 | Data bit count minus 5 |
| cfgParityEn | input | 1 | Append a parity bit |
| cfgParityEven | input | 1 | 1 = even parity, 0 = odd |
| cfgStop | input | 2 | 0 = 1 stop, 1 = 1.5 stop, 2/3 = 2 stop |
| cfgRate | input | 2 | 0 = x1, 1 = x16, 2/3 = x64 clock periods per bit |
| txEnable | input | 1 | Transmit enable |
| ctsN | input | 1 | Clear to send, active low |
| sendBreak | input | 1 | Force the line low |
| wrStrobe | input | 1 | One-cycle character write |
| wrByte | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| txRdy | output | 1 | Holding register free |
| txEmpty | output | 1 | Nothing held or in flight |

## Verification
The framing path is swept over every data length, parity choice and stop length at rates 1 and 16, plus a spread of cases at rate 64. Each captured waveform is compared sample by sample with a frame built arithmetically. This separates bit ordering, parity sense, masking of unused bits and stop length. Short directed sequences check back-to-back frames, gate closure mid-stream with a committed second character, a write under a closed gate, overwrite of a held character, and break. These show whether gating acts on frame boundaries and whether the commit rule follows the write time rather than the load time.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic load;      // move held character into the shifter, start bit out
    logic shift;     // advance to the next bit of the frame
    logic busy;      // a frame is on the line
    logic gateOpen;  // enable set and clear-to-send asserted
  } txStrobes_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MID_RATE    = 16,
  parameter int SLOW_RATE   = 64,
  parameter int DATA_W      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txClk,
  input  logic       txEnable,
  input  logic       ctsN,
  input  logic [1:0] cfgRate,
  input  logic [1:0] cfgStop,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParityEn,
  input  logic       holdPending,
  output txStrobes_t strobes,
  output logic       txEmpty
);

  localparam int LEN_W     = $clog2(2 * SLOW_RATE + 1);
  localparam int FRAME_MAX = DATA_W + 3;
  localparam int BITS_W    = $clog2(FRAME_MAX + 1);

  // Synchronizer plus one history flop for falling-edge detection
  logic [SYNC_STAGES:0] clkPipe;
  logic fallTick;

  always_ff @(posedge clk) begin
    if (rst) clkPipe <= '0;
    else     clkPipe <= {clkPipe[SYNC_STAGES-1:0], txClk};
  end

  assign fallTick = clkPipe[SYNC_STAGES] & ~clkPipe[SYNC_STAGES-1];

  // Per-frame timing selected from configuration
  logic [LEN_W-1:0]  unitSel, stopSel;
  logic [BITS_W-1:0] frameBitsSel;

  always_comb begin
    unique case (cfgRate)
      2'd0:    unitSel = LEN_W'(1);
      2'd1:    unitSel = LEN_W'(MID_RATE);
      default: unitSel = LEN_W'(SLOW_RATE);
    endcase
    unique case (cfgStop)
      2'd0:    stopSel = unitSel;
      2'd1:    stopSel = (cfgRate == 2'd0) ? LEN_W'(2) : unitSel + (unitSel >> 1);
      default: stopSel = unitSel << 1;
    endcase
    frameBitsSel = BITS_W'(DATA_W - 1) + BITS_W'(cfgDataBits) + BITS_W'(cfgParityEn);
  end

  // Frame sequencing state
  logic              busy;
  logic [LEN_W-1:0]  bitCnt, unitLen, stopLen, curLen;
  logic [BITS_W-1:0] bitsLeft;
  logic              lastBit, endBit, gateOpen, doLoad, doShift;

  assign lastBit  = (bitsLeft == BITS_W'(1));
  assign curLen   = lastBit ? stopLen : unitLen;
  assign endBit   = busy && fallTick && (bitCnt == curLen - LEN_W'(1));
  assign gateOpen = txEnable && !ctsN;
  assign doLoad   = fallTick && holdPending && (!busy || (endBit && lastBit));
  assign doShift  = endBit && !lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      bitCnt   <= '0;
      bitsLeft <= '0;
      unitLen  <= LEN_W'(1);
      stopLen  <= LEN_W'(1);
    end else if (doLoad) begin
      busy     <= 1'b1;
      bitCnt   <= '0;
      bitsLeft <= frameBitsSel;
      unitLen  <= unitSel;
      stopLen  <= stopSel;
    end else if (endBit) begin
      if (lastBit) busy <= 1'b0;
      bitCnt   <= '0;
      bitsLeft <= bitsLeft - BITS_W'(1);
    end else if (busy && fallTick) begin
      bitCnt <= bitCnt + LEN_W'(1);
    end
  end

  assign strobes.load     = doLoad;
  assign strobes.shift    = doShift;
  assign strobes.busy     = busy;
  assign strobes.gateOpen = gateOpen;
  assign txEmpty          = !busy && !holdPending;

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(fallTick) && $past(bitsLeft) == BITS_W'(1)));

  // R4
  bit_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bitCnt < curLen));

endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobes_t        strobes,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [1:0]        cfgDataBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityEven,
  input  logic              sendBreak,
  output logic              holdPending,
  output logic              txRdy,
  output logic              txd
);

  localparam int FRAME_W = DATA_W + 3;

  logic [DATA_W-1:0]  holdReg;
  logic               holdFull, holdGo;
  logic [FRAME_W-1:0] shReg, frameVec;
  logic [DATA_W-1:0]  maskedData;
  logic               parBit, lineBit;
  int                 nData;

  // Holding register and its commit flag
  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      holdGo   <= 1'b0;
    end else begin
      if (wrStrobe) holdReg <= wrByte;
      holdFull <= wrStrobe | (holdFull & ~strobes.load);
      if (wrStrobe)          holdGo <= strobes.gateOpen;
      else if (strobes.load) holdGo <= 1'b0;
      else                   holdGo <= holdGo | (holdFull & strobes.gateOpen);
    end
  end

  assign holdPending = holdFull && (strobes.gateOpen || holdGo);
  assign txRdy       = !holdFull;

  // Whole frame assembled at load time, LSB leaves first
  always_comb begin
    nData = DATA_W - 3 + int'(cfgDataBits);
    for (int i = 0; i < DATA_W; i++) maskedData[i] = holdReg[i] & (i < nData);
    parBit = cfgParityEven ? ^maskedData : ~^maskedData;
    frameVec = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nData) frameVec[i+1] = maskedData[i];
    for (int i = 1; i < FRAME_W; i++)
      if (cfgParityEn && i == nData + 1) frameVec[i] = parBit;
  end

  always_ff @(posedge clk) begin
    if (rst)                shReg <= '1;
    else if (strobes.load)  shReg <= frameVec;
    else if (strobes.shift) shReg <= {1'b1, shReg[FRAME_W-1:1]};
  end

  assign lineBit = strobes.busy ? shReg[0] : 1'b1;
  assign txd     = sendBreak ? 1'b0 : lineBit;

  // R6
  wr_clears_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |=> !txRdy);

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lineBit) |-> $past(strobes.load || strobes.shift));

  // R8
  load_gate_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |-> holdPending);

  // R2
  shift_busy_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.shift |-> strobes.busy);

endmodule

// File: rtl/sertx_frame_tx.sv
module sertx_frame_tx
  import sertx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MID_RATE    = 16,
  parameter int SLOW_RATE   = 64,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txClk,
  input  logic [1:0]        cfgDataBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityEven,
  input  logic [1:0]        cfgStop,
  input  logic [1:0]        cfgRate,
  input  logic              txEnable,
  input  logic              ctsN,
  input  logic              sendBreak,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrByte,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);

  txStrobes_t strobes;
  logic       holdPending;

  sertx_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .MID_RATE(MID_RATE),
    .SLOW_RATE(SLOW_RATE), .DATA_W(DATA_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .txClk(txClk),
    .txEnable(txEnable), .ctsN(ctsN),
    .cfgRate(cfgRate), .cfgStop(cfgStop),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .holdPending(holdPending), .strobes(strobes), .txEmpty(txEmpty)
  );

  sertx_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .wrStrobe(wrStrobe), .wrByte(wrByte),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityEven(cfgParityEven), .sendBreak(sendBreak),
    .holdPending(holdPending), .txRdy(txRdy), .txd(txd)
  );

endmodule

// File: tb/test_sertx_frame_tx.sv
`timescale 1ns/1ps
module test_sertx_frame_tx;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txClk = 1'b0;
  int   divCnt = 0;
  logic [1:0] cfgDataBits = 2'd3, cfgStop = 2'd0, cfgRate = 2'd0;
  logic cfgParityEn = 1'b0, cfgParityEven = 1'b0;
  logic txEnable = 1'b1, ctsN = 1'b0, sendBreak = 1'b0;
  logic wrStrobe = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic txd, txRdy, txEmpty;

  int checks = 0, fails = 0;
  logic cap [0:4095];
  int capCnt = 0;
  logic expBits [0:2047];
  int expLen = 0;

  always #2 clk = ~clk;

  // transmit clock: 8 system clocks per period, edges on clk falling edges
  always @(negedge clk) begin
    if (divCnt == 3) begin
      divCnt <= 0;
      txClk  <= ~txClk;
    end else divCnt <= divCnt + 1;
  end

  // one line sample per transmit clock period, mid-period
  always @(posedge txClk) begin
    cap[capCnt % 4096] <= txd;
    capCnt <= capCnt + 1;
  end

  sertx_frame_tx i_sertx_frame_tx (
    .clk(clk), .rst(rst), .txClk(txClk),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityEven(cfgParityEven), .cfgStop(cfgStop), .cfgRate(cfgRate),
    .txEnable(txEnable), .ctsN(ctsN), .sendBreak(sendBreak),
    .wrStrobe(wrStrobe), .wrByte(wrByte),
    .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #750000;
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] b);
    @(negedge clk);
    wrByte   = b;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitTx(input int n);
    repeat (n) @(posedge txClk);
    @(negedge clk);
  endtask

  task automatic addBits(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      expBits[expLen] = v;
      expLen++;
    end
  endtask

  // expected frame computed from the requirement text
  task automatic addFrame(input logic [7:0] d, input int db, input bit pe,
                          input bit pev, input int st, input int rt);
    int nb, unit, stopLen;
    logic x;
    nb   = 5 + db;
    unit = (rt == 0) ? 1 : (rt == 1) ? 16 : 64;
    if (st == 0)      stopLen = unit;
    else if (st == 1) stopLen = (rt == 0) ? 2 : (unit * 3) / 2;
    else              stopLen = 2 * unit;
    addBits(1'b0, unit);
    x = 1'b0;
    for (int i = 0; i < nb; i++) begin
      addBits(d[i], unit);
      x = x ^ d[i];
    end
    if (pe) addBits(pev ? x : ~x, unit);
    addBits(1'b1, stopLen);
  endtask

  // compare captured samples from startIdx: idle, expected frames, then idle
  task automatic checkCapture(input int startIdx, input string req);
    int first, bad, act, exv;
    first = -1;
    for (int i = startIdx; i < capCnt; i++)
      if (first < 0 && cap[i % 4096] == 1'b0) first = i;
    if (first < 0) begin
      check(1'b0, req, 1, 0);
    end else begin
      bad = -1; act = 0; exv = 0;
      for (int i = 0; i < expLen; i++)
        if (bad < 0 && cap[(first + i) % 4096] !== expBits[i]) begin
          bad = i; act = int'(cap[(first + i) % 4096]); exv = int'(expBits[i]);
        end
      for (int i = first + expLen; i < capCnt; i++)
        if (bad < 0 && cap[i % 4096] !== 1'b1) begin
          bad = i - first; act = int'(cap[i % 4096]); exv = 1;
        end
      if (bad >= 0) $display("  sample %0d of frame stream differs", bad);
      check(bad < 0, req, act, exv);
    end
    expLen = 0;
  endtask

  initial begin
    int idx, startIdx, lowSeen;
    logic [7:0] d;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1,     "R1 txd after reset", int'(txd), 1);
    check(txRdy === 1'b1,   "R1 txRdy after reset", int'(txRdy), 1);
    check(txEmpty === 1'b1, "R1 txEmpty after reset", int'(txEmpty), 1);

    // R2 R3 R4 R5 sweep of framing configurations
    idx = 0;
    for (int rt = 0; rt < 3; rt++)
      for (int db = 0; db < 4; db++)
        for (int pm = 0; pm < 3; pm++)
          for (int st = 0; st < 3; st++) begin
            if (rt == 2 && !((db == 0 && pm == 0) || (db == 3 && pm == 2 && st == 1))) continue;
            d = 8'((idx * 73 + 165) & 255);
            idx++;
            cfgRate = 2'(rt); cfgDataBits = 2'(db); cfgStop = 2'(st);
            cfgParityEn = (pm != 0); cfgParityEven = (pm == 2);
            addFrame(d, db, pm != 0, pm == 2, st, rt);
            startIdx = capCnt;
            doWrite(d);
            // R7 write with gate open drops empty flag next cycle
            check(txEmpty === 1'b0, "R7 txEmpty after write", int'(txEmpty), 0);
            waitTx(expLen + 4);
            checkCapture(startIdx, "R2 R3 R4 R5 frame stream");
            check(txEmpty === 1'b1 && txRdy === 1'b1, "R7 idle flags after frame",
                  int'({txEmpty, txRdy}), 3);
          end

    // R2 with rate encoding 3 and stop encoding 3 (alias x64, 2 stop)
    cfgRate = 2'd3; cfgStop = 2'd3; cfgDataBits = 2'd1; cfgParityEn = 1'b1; cfgParityEven = 1'b0;
    addFrame(8'hC6, 1, 1'b1, 1'b0, 2, 2);
    startIdx = capCnt;
    doWrite(8'hC6);
    waitTx(expLen + 4);
    checkCapture(startIdx, "R4 R5 alias encodings");

    // R6 R8 back-to-back under closing gate, x1, 8 bits, no parity, 1 stop
    cfgRate = 2'd0; cfgStop = 2'd0; cfgDataBits = 2'd3; cfgParityEn = 1'b0;
    addFrame(8'h3A, 3, 1'b0, 1'b0, 0, 0);
    addFrame(8'hD5, 3, 1'b0, 1'b0, 0, 0);
    startIdx = capCnt;
    doWrite(8'h3A);
    check(txRdy === 1'b0, "R6 txRdy low after write", int'(txRdy), 0);
    waitTx(2);
    check(txRdy === 1'b1, "R6 txRdy back after load", int'(txRdy), 1);
    doWrite(8'hD5);
    check(txRdy === 1'b0, "R6 txRdy low while held", int'(txRdy), 0);
    ctsN = 1'b1;
    waitTx(28);
    checkCapture(startIdx, "R6 R8 committed frames complete");
    check(txd === 1'b1 && txEmpty === 1'b1, "R8 idle after gated drain",
          int'({txd, txEmpty}), 3);

    // R9 write with gate closed: held, empty stays high, nothing sent
    startIdx = capCnt;
    doWrite(8'h96);
    @(negedge clk);
    check(txEmpty === 1'b1, "R9 txEmpty with gated write", int'(txEmpty), 1);
    check(txRdy === 1'b0, "R9 txRdy with gated write", int'(txRdy), 0);
    waitTx(20);
    lowSeen = 0;
    for (int i = startIdx; i < capCnt; i++) if (cap[i % 4096] == 1'b0) lowSeen++;
    check(lowSeen == 0, "R8 no frame while clear-to-send off", lowSeen, 0);
    addFrame(8'h96, 3, 1'b0, 1'b0, 0, 0);
    startIdx = capCnt;
    ctsN = 1'b0;
    waitTx(16);
    checkCapture(startIdx, "R9 sent after gate opens");

    // R10 overwrite while held under disabled transmitter
    txEnable = 1'b0;
    startIdx = capCnt;
    doWrite(8'h11);
    doWrite(8'hE4);
    waitTx(4);
    check(txEmpty === 1'b1, "R8 disabled: txEmpty high", int'(txEmpty), 1);
    addFrame(8'hE4, 3, 1'b0, 1'b0, 0, 0);
    txEnable = 1'b1;
    waitTx(30);
    checkCapture(startIdx, "R10 latest character only");

    // R11 break in idle and during a frame
    sendBreak = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R11 break idle", int'(txd), 0);
    repeat (20) @(negedge clk);
    check(txd === 1'b0, "R11 break held", int'(txd), 0);
    sendBreak = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R1 R11 release to mark", int'(txd), 1);
    doWrite(8'hFF);
    waitTx(3);
    sendBreak = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R11 break over data", int'(txd), 0);
    sendBreak = 1'b0;
    waitTx(12);
    check(txd === 1'b1 && txEmpty === 1'b1, "R1 idle after break frame",
          int'({txd, txEmpty}), 3);

    summary();
    $finish;
  end

endmodule